// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag and state side of a set-associative cache. It holds no data array and has no memory port. It takes one access at a time: an address and a read/write flag, presented on a valid/ready request interface. The address is split into a line offset, a set index and a tag. The controller then decides hit or miss, chooses a way to fill and updates the per-way metadata of the addressed set. It reports the outcome of each access as a one-cycle completion pulse, and it keeps running statistics counters.

Two run-time mode pins pick the replacement policy and the write policy. Replacement is either least-recently-used or an aged least-frequently-used scheme. Under the aged scheme a new line inherits the use count of the line it evicts, plus one, so fresh lines are not evicted at once by old, heavily used neighbours. Writes are handled either as write-back with write-allocate or as write-through without allocation. Both mode pins are sampled when a request is accepted. Block size, set count, associativity and counter widths are elaboration parameters.

Back-pressure works as follows. `req_ready` is high only while the controller is idle, and a request is taken on a rising edge where `req_valid` and `req_ready` are both high. In the cycle after acceptance `req_ready` is low, and the metadata is updated at the end of that cycle. In the next cycle `done_valid` pulses together with the result, and `req_ready` is high again. A source may hold `req_valid` high throughout, which gives one access every two cycles.

Top module: `cache_tag_ctrl`

## Requirements
- R1: With defaults (16-byte lines, 4 sets, 4 ways, 32-bit addresses), address bits [3:0] are the offset and are ignored, bits [5:4] are the set index, and bits [31:6] are the tag. Two addresses that differ only in the offset hit the same line.
- R2: An access hits only if a way of the indexed set is valid and holds the request tag. After reset every access misses.
- R3: A request is accepted on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the next cycle. `done_valid` is high for exactly the cycle after that, and `req_ready` is high again in that same cycle.
- R4: On a fill, the lowest-numbered invalid way of the set is used if any way is invalid.
- R5: With `cfg_lfu`=0 and all ways valid, the victim is the way with the oldest access stamp. Hits and fills both take a fresh stamp from one global access counter. The lowest way wins a tie.
- R6: With `cfg_lfu`=1 and all ways valid, the victim is the way with the smallest use count, and the lowest way wins a tie. A hit adds one to the count. A filled line's count is the replaced way's count plus one.
- R7: With `cfg_wt`=0, a write hit marks the line dirty and a write miss allocates a line marked dirty. Evicting a dirty line raises `done_wb` and increments `stat_wb`.
- R8: With `cfg_wt`=1, a write miss changes no metadata, so a later read of that line misses. Writes never mark a line dirty.
- R9: `stat_reads`, `stat_writes`, `stat_read_miss`, `stat_write_miss` and `stat_wb` each count their events, and they change only in the `done_valid` cycle.
- R10: Each access adds to `stat_traffic`. With `cfg_wt`=1 it adds 1 for a write or a read miss. With `cfg_wt`=0 it adds the miss bit plus the writeback bit. `done_mem` is high for a miss, and also for any write when `cfg_wt`=1.
- R11: While `rst` is high on a clock edge, all valid and dirty bits, counts, stamps, statistics and completion outputs are cleared, and `req_ready` is high afterwards.
- R12: `done_way` gives the hitting way on a hit and the filled way on a fill. It is 0 for a write-through write miss and outside the `done_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_lfu | input | 1 | 1: aged least-frequently-used replacement, 0: least-recently-used |
| cfg_wt | input | 1 | 1: write-through without allocation, 0: write-back with allocation |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| done_valid | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | Access hit |
| done_wb | output | 1 | A dirty line was evicted |
| done_mem | output | 1 | The access needs the next memory level |
| done_way | output | WAY_W | Way hit or filled |
| stat_reads | output | STAT_W | Read count |
| stat_read_miss | output | STAT_W | Read miss count |
| stat_writes | output | STAT_W | Write count |
| stat_write_miss | output | STAT_W | Write miss count |
| stat_wb | output | STAT_W | Writeback count |
| stat_traffic | output | STAT_W | Memory traffic count |

## Verification
An accepted request drops `req_ready` one edge later. Its completion flags, way number and updated counters appear two edges after the acceptance edge, and that access's metadata change is visible to the next request accepted from then on. The bench holds a behavioural model that steps on the same edges and keeps the same two-phase timing. It samples every output on the falling edge and compares it with the model, so each result is checked in exactly the cycle it is due. Directed sequences, with expected values worked out by hand, cover the victim order under each policy, dirty eviction, write-through non-allocation, a held-high request stream and reset. A long random stream then switches the modes between accesses.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_UPD  = 1'b1
  } ctc_state_e;

  function automatic int way_bits(input int ways);
    return (ways > 1) ? $clog2(ways) : 1;
  endfunction
endpackage

// File: rtl/ctc_tag_match.sv
module ctc_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]            row_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
  input  logic [TAG_W-1:0]           look_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;

  // one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = row_valid[w] && (row_tag[w] == look_tag);
  end

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w] && !hit) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/ctc_victim_sel.sv
module ctc_victim_sel #(
  parameter int WAYS  = 4,
  parameter int KEY_W = 16,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]            row_valid,
  input  logic [WAYS-1:0][KEY_W-1:0] row_key,
  output logic [WAY_W-1:0]           pick
);
  logic             have_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] min_way;
  logic [KEY_W-1:0] min_key;

  // lowest-numbered empty way
  always_comb begin
    have_free = 1'b0;
    free_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!row_valid[w] && !have_free) begin
        have_free = 1'b1;
        free_way  = WAY_W'(w);
      end
    end
  end

  // smallest key, strict compare keeps the lowest way on a tie
  always_comb begin
    min_key = row_key[0];
    min_way = '0;
    for (int w = 1; w < WAYS; w++) begin
      if (row_key[w] < min_key) begin
        min_key = row_key[w];
        min_way = WAY_W'(w);
      end
    end
  end

  assign pick = have_free ? free_way : min_way;
endmodule

// File: rtl/ctc_stats.sv
module ctc_stats #(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev,
  input  logic              ev_wr,
  input  logic              ev_miss,
  input  logic              ev_wb,
  input  logic              ev_wt,
  output logic [STAT_W-1:0] reads,
  output logic [STAT_W-1:0] read_miss,
  output logic [STAT_W-1:0] writes,
  output logic [STAT_W-1:0] write_miss,
  output logic [STAT_W-1:0] wbs,
  output logic [STAT_W-1:0] traffic
);
  logic [1:0] traffic_inc;

  always_comb begin
    if (ev_wt) traffic_inc = (ev_wr || ev_miss) ? 2'd1 : 2'd0;
    else       traffic_inc = {1'b0, ev_miss} + {1'b0, ev_wb};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reads      <= '0;
      read_miss  <= '0;
      writes     <= '0;
      write_miss <= '0;
      wbs        <= '0;
      traffic    <= '0;
    end else if (ev) begin
      if (ev_wr) begin
        writes <= writes + STAT_W'(1);
        if (ev_miss) write_miss <= write_miss + STAT_W'(1);
      end else begin
        reads <= reads + STAT_W'(1);
        if (ev_miss) read_miss <= read_miss + STAT_W'(1);
      end
      if (ev_wb) wbs <= wbs + STAT_W'(1);
      traffic <= traffic + STAT_W'(traffic_inc);
    end
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 16,
  parameter int NUM_SETS    = 4,
  parameter int WAYS        = 4,
  parameter int CNT_W       = 16,
  parameter int STAT_W      = 32,
  localparam int WAY_W      = way_bits(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_lfu,
  input  logic              cfg_wt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              done_valid,
  output logic              done_hit,
  output logic              done_wb,
  output logic              done_mem,
  output logic [WAY_W-1:0]  done_way,
  output logic [STAT_W-1:0] stat_reads,
  output logic [STAT_W-1:0] stat_read_miss,
  output logic [STAT_W-1:0] stat_writes,
  output logic [STAT_W-1:0] stat_write_miss,
  output logic [STAT_W-1:0] stat_wb,
  output logic [STAT_W-1:0] stat_traffic
);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int IDX_W  = $clog2(NUM_SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = ADDR_W - OFF_W;

  // request stage
  ctc_state_e        state_q;
  logic [LINE_W-1:0] rq_line;
  logic              rq_wr, rq_lfu, rq_wt;
  logic              accept, upd;
  logic              unused_offset;

  // per-set metadata
  logic [WAYS-1:0]            valid_q [NUM_SETS];
  logic [WAYS-1:0]            dirty_q [NUM_SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [NUM_SETS];
  logic [WAYS-1:0][CNT_W-1:0] cnt_q   [NUM_SETS];
  logic [WAYS-1:0][CNT_W-1:0] stamp_q [NUM_SETS];
  logic [CNT_W-1:0]           gctr_q;

  // lookup signals
  logic [IDX_W-1:0]           rq_idx;
  logic [TAG_W-1:0]           rq_tag;
  logic [WAYS-1:0][CNT_W-1:0] row_key;
  logic                       hit;
  logic [WAY_W-1:0]           hit_way, vic_way;
  logic                       do_fill, evict_dirty, mem_need;

  assign unused_offset = ^req_addr[OFF_W-1:0];

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign upd       = (state_q == ST_UPD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rq_line <= '0;
      rq_wr   <= 1'b0;
      rq_lfu  <= 1'b0;
      rq_wt   <= 1'b0;
    end else if (accept) begin
      state_q <= ST_UPD;
      rq_line <= req_addr[ADDR_W-1:OFF_W];
      rq_wr   <= req_write;
      rq_lfu  <= cfg_lfu;
      rq_wt   <= cfg_wt;
    end else begin
      state_q <= ST_IDLE;
    end
  end

  assign rq_idx = rq_line[IDX_W-1:0];
  assign rq_tag = rq_line[LINE_W-1:IDX_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      row_key[w] = rq_lfu ? cnt_q[rq_idx][w] : stamp_q[rq_idx][w];
  end

  ctc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .row_valid (valid_q[rq_idx]),
    .row_tag   (tag_q[rq_idx]),
    .look_tag  (rq_tag),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  ctc_victim_sel #(.WAYS(WAYS), .KEY_W(CNT_W), .WAY_W(WAY_W)) u_victim (
    .row_valid (valid_q[rq_idx]),
    .row_key   (row_key),
    .pick      (vic_way)
  );

  assign do_fill     = upd && !hit && !(rq_wr && rq_wt);
  assign evict_dirty = do_fill && valid_q[rq_idx][vic_way] && dirty_q[rq_idx][vic_way];
  assign mem_need    = !hit || (rq_wr && rq_wt);

  // metadata update at the end of the update cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      gctr_q <= '0;
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        tag_q[s]   <= '0;
        cnt_q[s]   <= '0;
        stamp_q[s] <= '0;
      end
    end else if (upd) begin
      if (hit) begin
        cnt_q[rq_idx][hit_way]   <= cnt_q[rq_idx][hit_way] + CNT_W'(1);
        stamp_q[rq_idx][hit_way] <= gctr_q;
        gctr_q                   <= gctr_q + CNT_W'(1);
        if (rq_wr && !rq_wt) dirty_q[rq_idx][hit_way] <= 1'b1;
      end else if (do_fill) begin
        // new line starts one above the count of the line it replaces
        cnt_q[rq_idx][vic_way]   <= cnt_q[rq_idx][vic_way] + CNT_W'(1);
        stamp_q[rq_idx][vic_way] <= gctr_q;
        gctr_q                   <= gctr_q + CNT_W'(1);
        tag_q[rq_idx][vic_way]   <= rq_tag;
        valid_q[rq_idx][vic_way] <= 1'b1;
        dirty_q[rq_idx][vic_way] <= rq_wr;
      end
    end
  end

  // completion pulse
  always_ff @(posedge clk) begin
    if (rst || !upd) begin
      done_valid <= 1'b0;
      done_hit   <= 1'b0;
      done_wb    <= 1'b0;
      done_mem   <= 1'b0;
      done_way   <= '0;
    end else begin
      done_valid <= 1'b1;
      done_hit   <= hit;
      done_wb    <= evict_dirty;
      done_mem   <= mem_need;
      done_way   <= hit ? hit_way : (do_fill ? vic_way : '0);
    end
  end

  ctc_stats #(.STAT_W(STAT_W)) u_stats (
    .clk        (clk),
    .rst        (rst),
    .ev         (upd),
    .ev_wr      (rq_wr),
    .ev_miss    (!hit),
    .ev_wb      (evict_dirty),
    .ev_wt      (rq_wt),
    .reads      (stat_reads),
    .read_miss  (stat_read_miss),
    .writes     (stat_writes),
    .write_miss (stat_write_miss),
    .wbs        (stat_wb),
    .traffic    (stat_traffic)
  );
endmodule

// File: rtl/ctc_checker.sv
module ctc_checker #(
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done_valid,
  input logic              done_hit,
  input logic              done_wb,
  input logic [STAT_W-1:0] stat_reads,
  input logic [STAT_W-1:0] stat_writes,
  input logic [STAT_W-1:0] stat_wb
);
  logic [STAT_W:0] acc_sum;
  assign acc_sum = {1'b0, stat_reads} + {1'b0, stat_writes};

  // R3
  accept_then_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && !done_valid));

  // R3
  busy_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> (done_valid && req_ready));

  // R7
  wb_not_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_hit) |-> !done_wb);

  // R9
  one_access_counted_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (acc_sum == $past(acc_sum) + (STAT_W+1)'(1)));

  // R9
  counts_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!done_valid && !$past(rst)) |-> (acc_sum == $past(acc_sum)));

  // R7
  wb_counter_step_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (stat_wb == $past(stat_wb) + STAT_W'(done_wb)));
endmodule

bind cache_tag_ctrl ctc_checker #(.STAT_W(STAT_W)) u_ctc_checker (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done_valid  (done_valid),
  .done_hit    (done_hit),
  .done_wb     (done_wb),
  .stat_reads  (stat_reads),
  .stat_writes (stat_writes),
  .stat_wb     (stat_wb)
);

// File: tb/cache_tag_ctrl_tb.sv
module cache_tag_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 4;
  localparam int NW   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_lfu = 1'b0, cfg_wt = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, done_valid, done_hit, done_wb, done_mem;
  logic [1:0]  done_way;
  logic [31:0] stat_reads, stat_read_miss, stat_writes, stat_write_miss, stat_wb, stat_traffic;

  int n_checks = 0;
  int n_errors = 0;
  bit started  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_tag_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_lfu(cfg_lfu), .cfg_wt(cfg_wt),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .done_valid(done_valid), .done_hit(done_hit), .done_wb(done_wb), .done_mem(done_mem),
    .done_way(done_way), .stat_reads(stat_reads), .stat_read_miss(stat_read_miss),
    .stat_writes(stat_writes), .stat_write_miss(stat_write_miss), .stat_wb(stat_wb),
    .stat_traffic(stat_traffic)
  );

  // ---------------- behavioural reference model ----------------
  int m_valid [SETS][NW];
  int m_dirty [SETS][NW];
  int m_tag   [SETS][NW];
  int m_cnt   [SETS][NW];
  int m_stamp [SETS][NW];
  int m_clock;
  int m_busy;
  int m_addr, m_wr, m_lfu, m_wt;
  int e_done, e_hit, e_wb, e_mem, e_way;
  int s_rd, s_rdm, s_wr, s_wrm, s_wb, s_traf;

  task automatic model_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < NW; w++) begin
        m_valid[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0;
        m_cnt[s][w] = 0;   m_stamp[s][w] = 0;
      end
    m_clock = 0; m_busy = 0;
    s_rd = 0; s_rdm = 0; s_wr = 0; s_wrm = 0; s_wb = 0; s_traf = 0;
  endtask

  task automatic model_access();
    int idx, tg, hw, vic, miss, wbv;
    idx = (m_addr >> 4) & 3;
    tg  = (m_addr >>> 6) & 32'h03FF_FFFF;
    hw  = -1;
    for (int w = 0; w < NW; w++)
      if (hw < 0 && m_valid[idx][w] != 0 && m_tag[idx][w] == tg) hw = w;
    miss = (hw < 0);
    wbv  = 0;
    e_way = 0;
    if (!miss) begin
      m_cnt[idx][hw]++;
      m_stamp[idx][hw] = m_clock++;
      if (m_wr != 0 && m_wt == 0) m_dirty[idx][hw] = 1;
      e_way = hw;
    end else if (!(m_wr != 0 && m_wt != 0)) begin
      vic = -1;
      for (int w = 0; w < NW; w++)
        if (vic < 0 && m_valid[idx][w] == 0) vic = w;
      if (vic < 0) begin
        vic = 0;
        for (int w = 1; w < NW; w++) begin
          if (m_lfu != 0) begin
            if (m_cnt[idx][w] < m_cnt[idx][vic]) vic = w;
          end else begin
            if (m_stamp[idx][w] < m_stamp[idx][vic]) vic = w;
          end
        end
      end
      wbv = (m_valid[idx][vic] != 0 && m_dirty[idx][vic] != 0);
      m_cnt[idx][vic]   = m_cnt[idx][vic] + 1;
      m_stamp[idx][vic] = m_clock++;
      m_tag[idx][vic]   = tg;
      m_valid[idx][vic] = 1;
      m_dirty[idx][vic] = m_wr;
      e_way = vic;
    end
    e_hit = !miss;
    e_wb  = wbv;
    e_mem = (m_wt != 0) ? (m_wr != 0 || miss) : miss;
    if (m_wr != 0) begin s_wr++; if (miss) s_wrm++; end
    else begin s_rd++; if (miss) s_rdm++; end
    if (wbv) s_wb++;
    if (m_wt != 0) s_traf += (m_wr != 0 || miss) ? 1 : 0;
    else s_traf += miss + wbv;
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      model_clear();
      e_done = 0; e_hit = 0; e_wb = 0; e_mem = 0; e_way = 0;
    end else if (m_busy != 0) begin
      model_access();
      e_done = 1;
      m_busy = 0;
    end else begin
      e_done = 0; e_hit = 0; e_wb = 0; e_mem = 0; e_way = 0;
      if (req_valid) begin
        m_busy = 1;
        m_addr = req_addr; m_wr = req_write; m_lfu = cfg_lfu; m_wt = cfg_wt;
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !finished) begin
      check("R3 req_ready",       req_ready, (m_busy == 0));
      check("R3 done_valid",      done_valid, e_done);
      check("R2 done_hit",        done_hit, e_hit);
      check("R7 done_wb",         done_wb, e_wb);
      check("R10 done_mem",       done_mem, e_mem);
      check("R12 done_way",       done_way, e_way);
      check("R9 stat_reads",      stat_reads, s_rd);
      check("R9 stat_read_miss",  stat_read_miss, s_rdm);
      check("R9 stat_writes",     stat_writes, s_wr);
      check("R9 stat_write_miss", stat_write_miss, s_wrm);
      check("R9 stat_wb",         stat_wb, s_wb);
      check("R10 stat_traffic",   stat_traffic, s_traf);
    end
  end

  // ---------------- stimulus ----------------
  logic h, wb, mm;
  int   wy;

  function automatic logic [31:0] line_addr(input int set, input int tg);
    return (32'(tg) << 6) | (32'(set) << 4);
  endfunction

  task automatic acc(input logic [31:0] a, input logic w,
                     output logic oh, output logic owb, output logic om, output int oway);
    req_addr = a; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    oh = done_hit; owb = done_wb; om = done_mem; oway = done_way;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    // R11 reset state
    check("R11 ready after reset", req_ready, 1);
    check("R11 done after reset", done_valid, 0);
    check("R11 stats after reset", stat_reads + stat_writes + stat_traffic, 0);

    // R2 / R1: cold miss then offset-only difference hits
    acc(32'h0000_0040, 1'b0, h, wb, mm, wy);
    check("R2 cold miss", h, 0);
    check("R4 first invalid way", wy, 0);
    acc(32'h0000_004F, 1'b0, h, wb, mm, wy);
    check("R1 offset ignored hit", h, 1);
    acc(32'h0000_0050, 1'b0, h, wb, mm, wy);
    check("R1 next set misses", h, 0);

    // R5 LRU victim order
    do_reset();
    cfg_lfu = 1'b0; cfg_wt = 1'b0;
    for (int t = 1; t <= 4; t++) acc(line_addr(0, t), 1'b0, h, wb, mm, wy);
    check("R4 fourth fill way", wy, 3);
    acc(line_addr(0, 1), 1'b0, h, wb, mm, wy);
    check("R5 hit refresh", h, 1);
    acc(line_addr(0, 5), 1'b0, h, wb, mm, wy);
    check("R5 lru victim way", wy, 1);
    acc(line_addr(0, 6), 1'b0, h, wb, mm, wy);
    check("R5 lru second victim", wy, 2);

    // R6 aged LFU
    do_reset();
    cfg_lfu = 1'b1;
    for (int t = 1; t <= 4; t++) acc(line_addr(0, t), 1'b0, h, wb, mm, wy);
    acc(line_addr(0, 1), 1'b0, h, wb, mm, wy);
    acc(line_addr(0, 1), 1'b0, h, wb, mm, wy);
    acc(line_addr(0, 2), 1'b0, h, wb, mm, wy);
    acc(line_addr(0, 3), 1'b0, h, wb, mm, wy);
    acc(line_addr(0, 5), 1'b0, h, wb, mm, wy);
    check("R6 lfu victim least used", wy, 3);
    acc(line_addr(0, 6), 1'b0, h, wb, mm, wy);
    check("R6 lfu tie lowest way", wy, 1);

    // R7 write-back dirty eviction
    do_reset();
    cfg_lfu = 1'b0; cfg_wt = 1'b0;
    acc(line_addr(1, 9), 1'b1, h, wb, mm, wy);
    check("R7 write miss allocates", wy, 0);
    check("R10 wb mode miss mem", mm, 1);
    for (int t = 2; t <= 4; t++) acc(line_addr(1, t), 1'b0, h, wb, mm, wy);
    acc(line_addr(1, 7), 1'b0, h, wb, mm, wy);
    check("R7 dirty evict wb", wb, 1);
    check("R7 evicted way", wy, 0);
    check("R7 wb counter", stat_wb, 1);
    check("R10 traffic wb mode", stat_traffic, 6);

    // R8 write-through no allocate
    do_reset();
    cfg_wt = 1'b1;
    acc(line_addr(2, 9), 1'b1, h, wb, mm, wy);
    check("R8 write miss mem", mm, 1);
    check("R12 no-alloc way", wy, 0);
    acc(line_addr(2, 9), 1'b0, h, wb, mm, wy);
    check("R8 not allocated", h, 0);
    acc(line_addr(2, 9), 1'b1, h, wb, mm, wy);
    check("R8 write hit", h, 1);
    check("R10 wt write hit mem", mm, 1);
    for (int t = 2; t <= 4; t++) acc(line_addr(2, t), 1'b0, h, wb, mm, wy);
    acc(line_addr(2, 7), 1'b0, h, wb, mm, wy);
    check("R8 clean evict", wb, 0);
    check("R10 traffic wt mode", stat_traffic, 7);

    // R3 held-high request stream
    req_addr = line_addr(3, 1); req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    check("R3 busy after accept", req_ready, 0);
    check("R3 no early done", done_valid, 0);
    @(negedge clk);
    check("R3 done pulse", done_valid, 1);
    check("R3 ready with done", req_ready, 1);
    @(negedge clk);
    check("R3 second accept", req_ready, 0);
    req_valid = 1'b0;
    @(negedge clk);
    check("R3 second done", done_valid, 1);
    check("R2 second is hit", done_hit, 1);

    // R11 mid-run reset
    do_reset();
    check("R11 stats cleared", stat_reads + stat_writes + stat_wb + stat_traffic, 0);
    acc(line_addr(2, 3), 1'b0, h, wb, mm, wy);
    check("R11 lines invalidated", h, 0);

    // random stream, modes switched between accesses
    for (int i = 0; i < 1500; i++) begin
      if (($urandom % 16) == 0) cfg_lfu = $urandom % 2;
      if (($urandom % 16) == 0) cfg_wt  = $urandom % 2;
      acc(line_addr($urandom % 4, $urandom % 8) | ($urandom % 16), $urandom % 2,
          h, wb, mm, wy);
      if (($urandom % 8) == 0) @(negedge clk);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule